// File: doc/BRIEF.md
# Banked Memory Mapper Register File

This block is the write side of a cartridge-style memory mapper. A host processor writes into the upper 32 KB of its address space. The block decodes those writes into a small set of control registers and turns them into bank numbers. The program space uses four 8 KB slots. The character space uses eight 1 KB slots. Alongside the bank numbers, the block drives a nametable mirroring select and the controls that gate the work RAM.

Banks are loaded in two steps. A write to the select register names one of eight bank registers and sets two layout modes. A following write to the data register fills the named bank register. The two layout modes swap which program slot is fixed to the second-to-last bank, and which half of the character space is built from paired 2 KB banks. Writes to the upper two register pairs are not used here. The block decodes them into a strobe for a separate interrupt counter.

Top module: `bank_mapper_regs`

## Requirements
- R1: A write is accepted only when wr_en is high and address bit 15 is 1. Only address bits 15, 14, 13 and 0 select the register. A write with address bit 15 equal to 0 changes no output.
- R2: A write with address bits {15,14,13,0} = 1000 is a select write. Data bits 2:0 name the bank register that the next data write targets. Bit 6 sets the program mode. Bit 7 sets the character mode.
- R3: A write with address bits {15,14,13,0} = 1001 is a data write. It stores the data into the bank register named by the last select write. When that index is 0 or 1, data bit 0 is stored as 0.
- R4: In program mode 0, program slots 0, 1, 2 and 3 give bank register 6, bank register 7, PRG_BANK_COUNT-2 and PRG_BANK_COUNT-1. Slot i is prg_bank_o[i*PRG_W +: PRG_W].
- R5: In program mode 1, program slots 0, 1, 2 and 3 give PRG_BANK_COUNT-2, bank register 7, bank register 6 and PRG_BANK_COUNT-1.
- R6: In character mode 0, character slots 0 and 1 give bank register 0 with bit 0 at 0 and at 1. Slots 2 and 3 do the same with bank register 1. Slots 4 to 7 give bank registers 2 to 5. Slot i is chr_bank_o[i*CHR_W +: CHR_W].
- R7: In character mode 1, slots 0 to 3 give bank registers 2 to 5. Slots 4 to 7 give the paired banks of registers 0 and 1, in the same order as in R6.
- R8: A write with address bits {15,14,13,0} = 1010 sets mirror_horiz_o to data bit 0. A value of 1 means horizontal mirroring and 0 means vertical.
- R9: A write with address bits {15,14,13,0} = 1011 sets wram_enable_o from data bit 7 and wram_wprot_o from data bit 6. wram_write_ok_o is high only when work RAM is enabled and not protected.
- R10: A synchronous low rst_n clears the select index, both modes, all eight bank registers, the mirroring select and both work-RAM controls. After reset the program slots read 0, 0, PRG_BANK_COUNT-2 and PRG_BANK_COUNT-1.
- R11: A write with address bits 15 and 14 both 1 leaves all bank, mirroring and work-RAM outputs unchanged. During that write cycle, irq_wr_o is high and irq_sel_o is {address bit 13, address bit 0}. Otherwise irq_wr_o is low.
- R12: Every bank output keeps only the low PRG_W or CHR_W bits of the stored register value. PRG_W is clog2(PRG_BANK_COUNT) and CHR_W is clog2(CHR_BANK_COUNT).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | 16 | Host write address |
| wr_data | input | 8 | Host write data |
| prg_bank_o | output | 4*PRG_W | Four program bank numbers, slot 0 in the low bits |
| chr_bank_o | output | 8*CHR_W | Eight character bank numbers, slot 0 in the low bits |
| mirror_horiz_o | output | 1 | 1 = horizontal, 0 = vertical mirroring |
| wram_enable_o | output | 1 | Work RAM enabled |
| wram_wprot_o | output | 1 | Work RAM write-protected |
| wram_write_ok_o | output | 1 | Work RAM writes allowed |
| irq_wr_o | output | 1 | Combinational strobe for a write to the interrupt register pairs |
| irq_sel_o | output | 2 | Which interrupt register: {address bit 13, address bit 0} |

## Verification
The assertions run on every cycle. They check that a write below the window leaves every output untouched, that a write to the interrupt pairs also leaves every output untouched, and that the mirroring and work-RAM gate follow the last write. They also check that a data write reaches the expected slot in the following cycle: register 7 in slot 1, register 6 in slot 0 or slot 2 depending on the program mode, and register 0 as a pair in the low character slots. Some properties can only be shown by the bench's scenarios. These are the full slot layout in each mode combination after long random write sequences, the reset values, the forced clearing of bit 0 for indices 0 and 1, and masking when a byte wider than the bank width is written.

// File: rtl/mmr_pkg.sv
// Shared definitions for the banked mapper register file.
// Assumes an 8-bit host data bus and eight bank registers.
package mmr_pkg;
    localparam int NUM_BANK_REGS = 8;
    localparam int IDX_W         = 3;
    localparam int HOST_DATA_W   = 8;

    // Register pair picked by address bits 14:13 inside the upper window.
    typedef enum logic [1:0] {
        PAIR_BANK   = 2'b00,
        PAIR_MIRRAM = 2'b01,
        PAIR_IRQ_LO = 2'b10,
        PAIR_IRQ_HI = 2'b11
    } pair_e;
endpackage

// File: rtl/mmr_decode.sv
// Address decoder. Turns a host write into one-cycle strobes.
// Looks only at address bits 15, 14, 13 and 0; the rest are ignored.
module mmr_decode
    import mmr_pkg::*;
(
    input  logic       wr_en,
    input  logic [3:0] addr_key,   // {A15, A14, A13, A0}
    output logic       sel_we,
    output logic       data_we,
    output logic       mirror_we,
    output logic       wram_we,
    output logic       irq_we,
    output logic [1:0] irq_sel
);
    pair_e pair;
    logic  in_window;

    // Pick the register pair and strobe the even or odd member.
    always_comb begin
        in_window = wr_en && addr_key[3];
        pair      = pair_e'(addr_key[2:1]);
        sel_we    = in_window && (pair == PAIR_BANK)   && !addr_key[0];
        data_we   = in_window && (pair == PAIR_BANK)   &&  addr_key[0];
        mirror_we = in_window && (pair == PAIR_MIRRAM) && !addr_key[0];
        wram_we   = in_window && (pair == PAIR_MIRRAM) &&  addr_key[0];
        irq_we    = in_window && addr_key[2];
        irq_sel   = {addr_key[1], addr_key[0]};
    end
endmodule

// File: rtl/mmr_bank_file.sv
// Holds the select byte fields, the eight bank registers and the
// mirroring / work-RAM control bits. Synchronous active-low reset.
module mmr_bank_file
    import mmr_pkg::*;
#(
    parameter int DATA_W = HOST_DATA_W
)(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            sel_we,
    input  logic                            data_we,
    input  logic                            mirror_we,
    input  logic                            wram_we,
    input  logic [DATA_W-1:0]               wr_data,
    output logic                            prg_mode,
    output logic                            chr_mode,
    output logic [NUM_BANK_REGS*DATA_W-1:0] regs_flat,
    output logic                            mirror_horiz,
    output logic                            wram_en,
    output logic                            wram_prot
);
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] bank_q [NUM_BANK_REGS];

    // Select byte: target index and the two layout modes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            prg_mode <= 1'b0;
            chr_mode <= 1'b0;
        end else if (sel_we) begin
            idx_q    <= wr_data[IDX_W-1:0];
            prg_mode <= wr_data[6];
            chr_mode <= wr_data[7];
        end
    end

    generate
        for (genvar g = 0; g < NUM_BANK_REGS; g++) begin : g_bank
            // Bank register g; the paired registers drop data bit 0.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bank_q[g] <= '0;
                else if (data_we && idx_q == IDX_W'(g))
                    bank_q[g] <= (g < 2) ? {wr_data[DATA_W-1:1], 1'b0} : wr_data;
            end
            assign regs_flat[g*DATA_W +: DATA_W] = bank_q[g];
        end
    endgenerate

    // Mirroring and work-RAM control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mirror_horiz <= 1'b0;
            wram_en      <= 1'b0;
            wram_prot    <= 1'b0;
        end else begin
            if (mirror_we) mirror_horiz <= wr_data[0];
            if (wram_we) begin
                wram_en   <= wr_data[7];
                wram_prot <= wr_data[6];
            end
        end
    end
endmodule

// File: rtl/mmr_slot_map.sv
// Combinational slot layout. Builds four program and eight character
// bank numbers from the bank registers and the two mode bits.
// Assumes PRG_BANK_COUNT >= 2; outputs keep only the low bank-width bits.
module mmr_slot_map
    import mmr_pkg::*;
#(
    parameter int DATA_W         = HOST_DATA_W,
    parameter int PRG_BANK_COUNT = 32,
    parameter int PRG_W          = 5,
    parameter int CHR_W          = 7
)(
    input  logic                            prg_mode,
    input  logic                            chr_mode,
    input  logic [NUM_BANK_REGS*DATA_W-1:0] regs_flat,
    output logic [4*PRG_W-1:0]              prg_bank,
    output logic [8*CHR_W-1:0]              chr_bank
);
    localparam logic [PRG_W-1:0] LAST_BANK   = PRG_W'(PRG_BANK_COUNT - 1);
    localparam logic [PRG_W-1:0] SECOND_LAST = PRG_W'(PRG_BANK_COUNT - 2);

    logic [PRG_W-1:0] r6_p, r7_p;
    logic             regs_unused;

    assign regs_unused = ^regs_flat;
    assign r6_p = regs_flat[6*DATA_W +: PRG_W];
    assign r7_p = regs_flat[7*DATA_W +: PRG_W];

    // Program slots: mode 1 swaps slot 0 and slot 2.
    always_comb begin
        prg_bank[0*PRG_W +: PRG_W] = prg_mode ? SECOND_LAST : r6_p;
        prg_bank[1*PRG_W +: PRG_W] = r7_p;
        prg_bank[2*PRG_W +: PRG_W] = prg_mode ? r6_p : SECOND_LAST;
        prg_bank[3*PRG_W +: PRG_W] = LAST_BANK;
    end

    generate
        for (genvar s = 0; s < 8; s++) begin : g_chr
            // Layout of slot s for one mode: slots 0..3 are paired, 4..7 direct.
            function automatic logic [CHR_W-1:0] layout(input int e);
                logic [CHR_W-1:0] v;
                if (e < 4) begin
                    v    = regs_flat[(e/2)*DATA_W +: CHR_W];
                    v[0] = e[0];
                end else begin
                    v = regs_flat[(e-2)*DATA_W +: CHR_W];
                end
                return v;
            endfunction
            // Character slot s: mode 1 takes the layout of slot s with halves swapped.
            assign chr_bank[s*CHR_W +: CHR_W] = chr_mode ? layout(s ^ 4) : layout(s);
        end
    endgenerate
endmodule

// File: rtl/bank_mapper_regs.sv
// Top of the banked mapper register file: write decode, register
// storage and slot layout. Writes take effect on the next clock edge.
// The interrupt strobe is combinational from the write inputs.
module bank_mapper_regs
    import mmr_pkg::*;
#(
    parameter int PRG_BANK_COUNT = 32,
    parameter int CHR_BANK_COUNT = 128,
    localparam int PRG_W = $clog2(PRG_BANK_COUNT),
    localparam int CHR_W = $clog2(CHR_BANK_COUNT)
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [15:0]        wr_addr,
    input  logic [7:0]         wr_data,
    output logic [4*PRG_W-1:0] prg_bank_o,
    output logic [8*CHR_W-1:0] chr_bank_o,
    output logic               mirror_horiz_o,
    output logic               wram_enable_o,
    output logic               wram_wprot_o,
    output logic               wram_write_ok_o,
    output logic               irq_wr_o,
    output logic [1:0]         irq_sel_o
);
    logic sel_we, data_we, mirror_we, wram_we;
    logic prg_mode, chr_mode, wram_en, wram_prot;
    logic [NUM_BANK_REGS*HOST_DATA_W-1:0] regs_flat;
    logic addr_unused;

    assign addr_unused = ^wr_addr[12:1];

    mmr_decode u_dec (
        .wr_en    (wr_en),
        .addr_key ({wr_addr[15:13], wr_addr[0]}),
        .sel_we   (sel_we),
        .data_we  (data_we),
        .mirror_we(mirror_we),
        .wram_we  (wram_we),
        .irq_we   (irq_wr_o),
        .irq_sel  (irq_sel_o)
    );

    mmr_bank_file #(.DATA_W(HOST_DATA_W)) u_file (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_we      (sel_we),
        .data_we     (data_we),
        .mirror_we   (mirror_we),
        .wram_we     (wram_we),
        .wr_data     (wr_data),
        .prg_mode    (prg_mode),
        .chr_mode    (chr_mode),
        .regs_flat   (regs_flat),
        .mirror_horiz(mirror_horiz_o),
        .wram_en     (wram_en),
        .wram_prot   (wram_prot)
    );

    mmr_slot_map #(
        .DATA_W        (HOST_DATA_W),
        .PRG_BANK_COUNT(PRG_BANK_COUNT),
        .PRG_W         (PRG_W),
        .CHR_W         (CHR_W)
    ) u_map (
        .prg_mode (prg_mode),
        .chr_mode (chr_mode),
        .regs_flat(regs_flat),
        .prg_bank (prg_bank_o),
        .chr_bank (chr_bank_o)
    );

    // Work-RAM gate: writes only when enabled and not protected.
    always_comb begin
        wram_enable_o   = wram_en;
        wram_wprot_o    = wram_prot;
        wram_write_ok_o = wram_en && !wram_prot;
    end
endmodule

// File: rtl/mmr_checker.sv
// Checker for bank_mapper_regs, bound to every instance of the top.
// It keeps its own copy of the last select byte so that data writes
// can be tied to their target slots.
module mmr_checker #(
    parameter int PRG_W = 5,
    parameter int CHR_W = 7
)(
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [15:0]        wr_addr,
    input logic [7:0]         wr_data,
    input logic [4*PRG_W-1:0] prg_bank_o,
    input logic [8*CHR_W-1:0] chr_bank_o,
    input logic               mirror_horiz_o,
    input logic               wram_enable_o,
    input logic               wram_wprot_o,
    input logic               wram_write_ok_o
);
    logic [2:0] sh_idx;
    logic       sh_pm, sh_cm;
    logic       is_sel, is_data, is_mir, is_ram, is_low, is_irq;

    assign is_sel  = wr_en && wr_addr[15:13] == 3'b100 && !wr_addr[0];
    assign is_data = wr_en && wr_addr[15:13] == 3'b100 &&  wr_addr[0];
    assign is_mir  = wr_en && wr_addr[15:13] == 3'b101 && !wr_addr[0];
    assign is_ram  = wr_en && wr_addr[15:13] == 3'b101 &&  wr_addr[0];
    assign is_low  = wr_en && !wr_addr[15];
    assign is_irq  = wr_en && wr_addr[15] && wr_addr[14];

    // Shadow of the select byte fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_idx <= '0; sh_pm <= 1'b0; sh_cm <= 1'b0;
        end else if (is_sel) begin
            sh_idx <= wr_data[2:0]; sh_pm <= wr_data[6]; sh_cm <= wr_data[7];
        end
    end

    p_low_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        is_low |=> $stable(prg_bank_o) && $stable(chr_bank_o)
                   && $stable(mirror_horiz_o) && $stable(wram_enable_o) && $stable(wram_wprot_o));

    p_reg7_slot1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_data && sh_idx == 3'd7) |=> prg_bank_o[PRG_W +: PRG_W] == $past(wr_data[PRG_W-1:0]));

    p_reg6_mode0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_data && sh_idx == 3'd6 && !sh_pm) |=> prg_bank_o[0 +: PRG_W] == $past(wr_data[PRG_W-1:0]));

    p_reg6_mode1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_data && sh_idx == 3'd6 && sh_pm) |=> prg_bank_o[2*PRG_W +: PRG_W] == $past(wr_data[PRG_W-1:0]));

    p_pair_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_data && sh_idx == 3'd0 && !sh_cm) |=>
            chr_bank_o[0 +: CHR_W] == {$past(wr_data[CHR_W-1:1]), 1'b0}
            && chr_bank_o[CHR_W +: CHR_W] == {$past(wr_data[CHR_W-1:1]), 1'b1});

    p_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_mir |=> mirror_horiz_o == $past(wr_data[0]));

    p_wram_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        is_ram |=> wram_write_ok_o == ($past(wr_data[7]) && !$past(wr_data[6])));

    p_irq_no_effect_r11: assert property (@(posedge clk) disable iff (!rst_n)
        is_irq |=> $stable(prg_bank_o) && $stable(chr_bank_o)
                   && $stable(mirror_horiz_o) && $stable(wram_write_ok_o));
endmodule

bind bank_mapper_regs mmr_checker #(.PRG_W(PRG_W), .CHR_W(CHR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prg_bank_o(prg_bank_o), .chr_bank_o(chr_bank_o), .mirror_horiz_o(mirror_horiz_o),
    .wram_enable_o(wram_enable_o), .wram_wprot_o(wram_wprot_o),
    .wram_write_ok_o(wram_write_ok_o)
);

// File: tb/bank_mapper_regs_test.sv
// Bench for bank_mapper_regs: directed corners plus seeded random writes,
// compared against a bench-side model of the requirements.
module bank_mapper_regs_test;
    localparam int CLK_PERIOD = 10;
    localparam int PRG_COUNT  = 32;
    localparam int CHR_COUNT  = 128;
    localparam int PW = $clog2(PRG_COUNT);
    localparam int CW = $clog2(CHR_COUNT);

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [4*PW-1:0] prg_bank_o;
    logic [8*CW-1:0] chr_bank_o;
    logic mirror_horiz_o, wram_enable_o, wram_wprot_o, wram_write_ok_o, irq_wr_o;
    logic [1:0] irq_sel_o;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [7:0] m_reg [8];
    logic [2:0] m_idx;
    logic m_pm, m_cm, m_mir, m_en, m_pr;

    bank_mapper_regs #(.PRG_BANK_COUNT(PRG_COUNT), .CHR_BANK_COUNT(CHR_COUNT)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [4*PW-1:0] exp_prg();
        logic [PW-1:0] r6 = m_reg[6][PW-1:0], r7 = m_reg[7][PW-1:0];
        logic [PW-1:0] sl = PW'(PRG_COUNT-2), la = PW'(PRG_COUNT-1);
        return m_pm ? {la, r6, r7, sl} : {la, sl, r7, r6};
    endfunction

    function automatic logic [CW-1:0] chr_slot(input int e);
        logic [CW-1:0] v;
        if (e < 4) begin
            v = m_reg[e/2][CW-1:0];
            v[0] = e[0];
        end else v = m_reg[e-2][CW-1:0];
        return v;
    endfunction

    function automatic logic [8*CW-1:0] exp_chr();
        logic [8*CW-1:0] v;
        for (int s = 0; s < 8; s++) v[s*CW +: CW] = chr_slot(m_cm ? (s ^ 4) : s);
        return v;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_reg[i] = '0;
        m_idx = '0; m_pm = 0; m_cm = 0; m_mir = 0; m_en = 0; m_pr = 0;
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R4/R5 prg slots"}, 64'(prg_bank_o), 64'(exp_prg()));
        chk({tag, " R6/R7 chr slots"}, 64'(chr_bank_o), 64'(exp_chr()));
        chk({tag, " R8 mirror"}, 64'(mirror_horiz_o), 64'(m_mir));
        chk({tag, " R9 wram"}, 64'({wram_enable_o, wram_wprot_o, wram_write_ok_o}),
            64'({m_en, m_pr, m_en && !m_pr}));
    endtask

    // One host write: drive at a falling edge, capture at the rising edge,
    // then update the model and compare at the next falling edge.
    task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        #1;
        chk("R11 irq strobe", 64'({irq_wr_o, irq_wr_o ? irq_sel_o : 2'b00}),
            64'({a[15] && a[14], (a[15] && a[14]) ? {a[13], a[0]} : 2'b00}));
        @(negedge clk);
        wr_en = 1'b0;
        if (a[15]) begin
            case ({a[14:13], a[0]})
                3'b000: begin m_idx = d[2:0]; m_pm = d[6]; m_cm = d[7]; end
                3'b001: m_reg[m_idx] = (m_idx <= 1) ? {d[7:1], 1'b0} : d;
                3'b010: m_mir = d[0];
                3'b011: begin m_en = d[7]; m_pr = d[6]; end
                default: ;
            endcase
        end
        check_all(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 reset prg", 64'(prg_bank_o), 64'({5'd31, 5'd30, 5'd0, 5'd0}));
        check_all("R10");

        // R2/R3/R12: fill all registers with all-ones, index 0/1 lose bit 0
        for (int i = 0; i < 8; i++) begin
            wr(16'h8000, 8'(i), "R2");
            wr(16'h8001, 8'hFF, "R3");
        end
        chk("R3 reg0 bit0 cleared", 64'(chr_bank_o[0 +: CW]), 64'(7'h7E));
        chk("R12 mask prg slot0", 64'(prg_bank_o[0 +: PW]), 64'(5'h1F));
        // R2: both modes set by a select byte
        wr(16'h8000, 8'hC6, "R2");
        chk("R5 slot0 fixed", 64'(prg_bank_o[0 +: PW]), 64'(PRG_COUNT-2));
        chk("R7 slot4 paired", 64'(chr_bank_o[4*CW +: CW]), 64'(7'h7E));
        wr(16'h8001, 8'h05, "R5");
        chk("R5 reg6 in slot2", 64'(prg_bank_o[2*PW +: PW]), 64'(5));
        // R1: aliases with middle address bits set still decode
        wr(16'h9FFE, 8'h01, "R1");
        wr(16'h9FFF, 8'h13, "R1");
        wr(16'hBFFE, 8'h01, "R8");
        wr(16'hA001, 8'h80, "R9");
        wr(16'hA001, 8'hC0, "R9");
        wr(16'h7FFF, 8'h55, "R1 low write ignored");
        wr(16'h0000, 8'hFF, "R1 low write ignored");
        wr(16'hC000, 8'h00, "R11");
        wr(16'hE001, 8'hFF, "R11");

        // Random mix, biased toward the bank pair.
        for (int n = 0; n < 600; n++) begin
            logic [15:0] a = 16'($urandom);
            if ($urandom_range(0, 2) == 0) a[15:13] = 3'b100;
            wr(a, 8'($urandom), "random");
        end

        // R10: reset again in the middle of activity
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; model_reset();
        @(negedge clk);
        check_all("R10 re-reset");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule